// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block drives a two-wire I2C bus as the only master on it. It takes one command at a time and turns it into the exact SCL and SDA waveform that the command needs. There are four commands: start-with-address, write byte, read byte and stop. Both bus lines are open-drain. The block therefore never drives a line high: it outputs a pull-low enable for each line and reads the SDA wire back through a separate input.

All timing derives from a 1 µs tick. The tick comes from a divider of the system clock, and the divider restarts whenever a command is accepted. Every bus phase lasts a whole number of ticks and uses standard-mode values. A byte transfer reports the acknowledge it received. A read returns the byte it assembled. An address command with a reserved address is refused without touching the bus.

Commands use a valid/ready handshake. Along with the command come a data byte, a read/write bit for addressing, a stop request and a last-byte flag.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset, both pull-low enables are 0, `cmd_ready` is 1, and `ack_err` and `addr_err` are 0.
- R2: An address command (`cmd_op` = 0) first releases both lines for 5 ticks. It then pulls SDA low with SCL released for 4 ticks, then pulls both lines low for 5 ticks.
- R3: A written bit is sent in three steps. SCL is low for 1 tick with SDA already set to the bit value. SCL is then released for 4 ticks. SCL is then low for 5 ticks. SDA holds the bit value through all three steps, and the most significant bit goes first.
- R4: After the 8th written bit, SDA is released and SCL stays low for 5 ticks. SCL is then released for 4 ticks, and SDA is sampled at the end of that high time. SCL is then low for 5 ticks. A sampled high sets `ack_err` to 1; a sampled low leaves it at 0.
- R5: A read (`cmd_op` = 2) keeps SDA released and clocks 8 bits. Each bit has SCL released for 4 ticks, with SDA sampled at the end, followed by SCL low for 5 ticks. The bits are assembled most significant first and appear on `rd_data` once the byte completes.
- R6: After a read, the master sends its acknowledge bit with the R3 timing. It pulls SDA low when `cmd_last` is 0 and releases SDA when `cmd_last` is 1. It then releases SDA with SCL low for 5 ticks.
- R7: A stop holds SDA low with SCL released for 4 ticks, then releases both lines. A stop is added after a write (`cmd_op` = 1) when `cmd_stop` is 1. It is added after a read only when `cmd_stop` and `cmd_last` are both 1. A stop command (`cmd_op` = 3) issues just the stop.
- R8: An address command sends the byte `{cmd_data[6:0], cmd_rnw}` using the R3/R4 sequence, with no stop afterwards whatever the value of `cmd_stop`. While idle without a stop, SCL stays pulled low and SDA stays released.
- R9: An address command with `cmd_data[6:3]` = 4'b1111 sets `addr_err` in the cycle after acceptance. The bus lines do not change and `cmd_ready` stays 1.
- R10: `cmd_ready` falls only on acceptance and stays low until the final phase ends. `ack_err` and `addr_err` are cleared on acceptance and otherwise keep their value while idle, and `rd_data` does too.
- R11: While the engine is busy, a valid command is not accepted and does not disturb the waveform under way.
- R12: One tick lasts `CLK_HZ/TICK_HZ` clock cycles, and each phase lasts exactly its tick count multiplied by that divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 stop |
| cmd_data | input | 8 | Write byte, or address in bits 6:0 |
| cmd_rnw | input | 1 | Direction bit placed in the address byte (1 = read) |
| cmd_stop | input | 1 | Request a stop after this byte |
| cmd_last | input | 1 | Final read byte: answer with no-acknowledge |
| rd_data | output | 8 | Last byte read |
| ack_err | output | 1 | Last written byte was not acknowledged |
| addr_err | output | 1 | Last address command was reserved and refused |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Level seen on the SDA wire |

## Verification
The bench builds the engine with `CLK_HZ` = 2 and `TICK_HZ` = 1, so a tick lasts two clocks. A full byte then completes in about two hundred cycles, which makes it practical to sweep all 128 addresses, all 256 write values and 128 read values inside the run. The bench also models the slave on SDA: it answers acknowledges in alternating patterns and shifts out read data. It rebuilds the expected line sequence for every command and compares the lines in every cycle of every phase. Stop handling is exercised with every combination of the stop and last flags.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IW = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [4:0] {
    PH_IDLE, PH_BUSFREE, PH_SHOLD, PH_SLOW,
    PH_WSU, PH_WHI, PH_WLO,
    PH_AREL, PH_AHI, PH_ALO,
    PH_RHI, PH_RLO,
    PH_MSU, PH_MHI, PH_MLO, PH_MREL,
    PH_PSU
  } phase_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] TOP = DW'(DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == TOP);
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int T_BUF   = 5,
  parameter int T_SHOLD = 4,
  parameter int T_LOW   = 5,
  parameter int T_SU    = 1,
  parameter int T_HIGH  = 4,
  parameter int T_PSU   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cmd_rnw,
  input  logic              cmd_stop,
  input  logic              cmd_last,
  input  logic              sda_in,
  output logic              cmd_ready,
  output logic              restart,
  output phase_e            phase,
  output logic              tx_bit,
  output logic              last_q,
  output logic              bus_open,
  output logic [BYTE_W-1:0] rd_data,
  output logic              ack_err,
  output logic              addr_err
);
  localparam int M1 = (T_BUF > T_LOW) ? T_BUF : T_LOW;
  localparam int M2 = (T_SHOLD > T_HIGH) ? T_SHOLD : T_HIGH;
  localparam int M3 = (T_SU > T_PSU) ? T_SU : T_PSU;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M4 > M3) ? M4 : M3;
  localparam int CW = $clog2(MAXT + 1);

  logic [CW-1:0]     cnt;
  logic [BIT_IW-1:0] bitn;
  logic [BYTE_W-1:0] sreg;
  logic              stop_q;
  phase_e            nxt;
  op_e               op;
  logic              accept, step, bad_addr, last_bit;

  function automatic logic [CW-1:0] lim(phase_e p);
    case (p)
      PH_BUSFREE:                   lim = CW'(T_BUF - 1);
      PH_SHOLD:                     lim = CW'(T_SHOLD - 1);
      PH_WSU, PH_MSU:               lim = CW'(T_SU - 1);
      PH_WHI, PH_AHI, PH_RHI, PH_MHI: lim = CW'(T_HIGH - 1);
      PH_PSU:                       lim = CW'(T_PSU - 1);
      PH_IDLE:                      lim = '0;
      default:                      lim = CW'(T_LOW - 1);
    endcase
  endfunction

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign restart   = accept;
  assign step      = tick && (phase != PH_IDLE);
  assign bad_addr  = (cmd_data[6:3] == 4'hF);
  assign last_bit  = (bitn == BIT_IW'(BYTE_W - 1));
  assign tx_bit    = sreg[BYTE_W-1];

  always_comb begin
    case (phase)
      PH_BUSFREE: nxt = PH_SHOLD;
      PH_SHOLD:   nxt = PH_SLOW;
      PH_SLOW:    nxt = PH_WSU;
      PH_WSU:     nxt = PH_WHI;
      PH_WHI:     nxt = PH_WLO;
      PH_WLO:     nxt = last_bit ? PH_AREL : PH_WSU;
      PH_AREL:    nxt = PH_AHI;
      PH_AHI:     nxt = PH_ALO;
      PH_ALO:     nxt = stop_q ? PH_PSU : PH_IDLE;
      PH_RHI:     nxt = PH_RLO;
      PH_RLO:     nxt = last_bit ? PH_MSU : PH_RHI;
      PH_MSU:     nxt = PH_MHI;
      PH_MHI:     nxt = PH_MLO;
      PH_MLO:     nxt = PH_MREL;
      PH_MREL:    nxt = (stop_q && last_q) ? PH_PSU : PH_IDLE;
      default:    nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sreg     <= '0;
      stop_q   <= 1'b0;
      last_q   <= 1'b0;
      bus_open <= 1'b1;
      rd_data  <= '0;
      ack_err  <= 1'b0;
      addr_err <= 1'b0;
    end else if (accept) begin
      ack_err  <= 1'b0;
      addr_err <= 1'b0;
      stop_q   <= cmd_stop;
      last_q   <= cmd_last;
      bitn     <= '0;
      case (op)
        OP_ADDR: begin
          if (bad_addr) begin
            addr_err <= 1'b1;
          end else begin
            sreg     <= {cmd_data[BYTE_W-2:0], cmd_rnw};
            stop_q   <= 1'b0;
            bus_open <= 1'b0;
            phase    <= PH_BUSFREE;
            cnt      <= lim(PH_BUSFREE);
          end
        end
        OP_WRITE: begin
          sreg     <= cmd_data;
          bus_open <= 1'b0;
          phase    <= PH_WSU;
          cnt      <= lim(PH_WSU);
        end
        OP_READ: begin
          sreg     <= '0;
          bus_open <= 1'b0;
          phase    <= PH_RHI;
          cnt      <= lim(PH_RHI);
        end
        default: begin
          phase <= PH_PSU;
          cnt   <= lim(PH_PSU);
        end
      endcase
    end else if (step) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        phase <= nxt;
        cnt   <= lim(nxt);
        case (phase)
          PH_WLO: begin
            if (last_bit) bitn <= '0;
            else begin
              bitn <= bitn + 1'b1;
              sreg <= sreg << 1;
            end
          end
          PH_AHI: ack_err <= sda_in;
          PH_RHI: sreg <= {sreg[BYTE_W-2:0], sda_in};
          PH_RLO: begin
            if (last_bit) begin
              bitn    <= '0;
              rd_data <= sreg;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
          PH_PSU: bus_open <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_drive.sv
module i2cm_drive
  import i2cm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  input  logic   tx_bit,
  input  logic   last_q,
  input  logic   bus_open,
  output logic   scl_low,
  output logic   sda_low
);
  logic scl_d, sda_d;

  always_comb begin
    case (phase)
      PH_IDLE:    begin scl_d = !bus_open; sda_d = 1'b0;    end
      PH_BUSFREE: begin scl_d = 1'b0;      sda_d = 1'b0;    end
      PH_SHOLD:   begin scl_d = 1'b0;      sda_d = 1'b1;    end
      PH_SLOW:    begin scl_d = 1'b1;      sda_d = 1'b1;    end
      PH_WSU,
      PH_WLO:     begin scl_d = 1'b1;      sda_d = !tx_bit; end
      PH_WHI:     begin scl_d = 1'b0;      sda_d = !tx_bit; end
      PH_AHI,
      PH_RHI:     begin scl_d = 1'b0;      sda_d = 1'b0;    end
      PH_MSU,
      PH_MLO:     begin scl_d = 1'b1;      sda_d = !last_q; end
      PH_MHI:     begin scl_d = 1'b0;      sda_d = !last_q; end
      PH_PSU:     begin scl_d = 1'b0;      sda_d = 1'b1;    end
      default:    begin scl_d = 1'b1;      sda_d = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      scl_low <= scl_d;
      sda_low <= sda_d;
    end
  end
endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master
  import i2cm_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TICK_HZ = 1_000_000,
  parameter int T_BUF   = 5,
  parameter int T_SHOLD = 4,
  parameter int T_LOW   = 5,
  parameter int T_SU    = 1,
  parameter int T_HIGH  = 4,
  parameter int T_PSU   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_rnw,
  input  logic       cmd_stop,
  input  logic       cmd_last,
  output logic [7:0] rd_data,
  output logic       ack_err,
  output logic       addr_err,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       sda_in
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic   tick, restart, tx_bit, last_q, bus_open;
  phase_e phase;

  i2cm_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  i2cm_seq #(
    .T_BUF(T_BUF), .T_SHOLD(T_SHOLD), .T_LOW(T_LOW),
    .T_SU(T_SU), .T_HIGH(T_HIGH), .T_PSU(T_PSU)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_rnw(cmd_rnw), .cmd_stop(cmd_stop), .cmd_last(cmd_last),
    .sda_in(sda_in), .cmd_ready(cmd_ready), .restart(restart),
    .phase(phase), .tx_bit(tx_bit), .last_q(last_q), .bus_open(bus_open),
    .rd_data(rd_data), .ack_err(ack_err), .addr_err(addr_err)
  );

  i2cm_drive u_drive (
    .clk(clk), .rst(rst), .phase(phase), .tx_bit(tx_bit),
    .last_q(last_q), .bus_open(bus_open),
    .scl_low(scl_low), .sda_low(sda_low)
  );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_rnw,
  input logic       cmd_stop,
  input logic       cmd_last,
  input logic [7:0] rd_data,
  input logic       ack_err,
  input logic       addr_err,
  input logic       scl_low,
  input logic       sda_low,
  input logic       sda_in
);
  logic rst_d = 1'b0;
  logic bad_cmd;

  assign bad_cmd = (cmd_op == 2'd0) && (cmd_data[6:3] == 4'hF);

  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_d && !rst) begin
      reset_state_chk: assert (!scl_low && !sda_low && cmd_ready && !ack_err && !addr_err);
    end
  end

  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && bad_cmd) |=>
      (addr_err && cmd_ready && $stable(scl_low) && $stable(sda_low)));

  // R10
  accept_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !bad_cmd) |=> (!cmd_ready && !ack_err && !addr_err));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_ready) |-> $past(cmd_valid));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_ready && !cmd_valid) && cmd_ready) |->
      ($stable(ack_err) && $stable(addr_err) && $stable(rd_data)));
endmodule

bind i2c_bit_master i2cm_chk u_chk (.*);

// File: tb/i2c_bit_master_bench.sv
module i2c_bit_master_bench;
  localparam int CLK_HZ  = 2;
  localparam int TICK_HZ = 1;
  localparam int DIV     = CLK_HZ / TICK_HZ;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       cmd_rnw = 1'b0, cmd_stop = 1'b0, cmd_last = 1'b0;
  logic [7:0] rd_data;
  logic       ack_err, addr_err, scl_low, sda_low;
  logic       slave_pull = 1'b0;
  logic       sda_in;

  assign sda_in = !(sda_low || slave_pull);

  always #4 clk = !clk;

  i2c_bit_master #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_i2c_bit_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_rnw(cmd_rnw),
    .cmd_stop(cmd_stop), .cmd_last(cmd_last), .rd_data(rd_data),
    .ack_err(ack_err), .addr_err(addr_err), .scl_low(scl_low),
    .sda_low(sda_low), .sda_in(sda_in)
  );

  int   n_chk = 0, n_fail = 0;
  logic seg_scl [64];
  logic seg_sda [64];
  logic seg_pull[64];
  int   seg_t   [64];
  int   nseg;
  logic open_exp = 1'b1;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add(input logic s, input logic d, input logic p, input int t);
    seg_scl[nseg] = s; seg_sda[nseg] = d; seg_pull[nseg] = p; seg_t[nseg] = t;
    nseg++;
  endtask

  task automatic add_wbyte(input logic [7:0] v, input logic ack, input logic stop);
    for (int i = 7; i >= 0; i--) begin
      add(1'b1, !v[i], 1'b0, 1); add(1'b0, !v[i], 1'b0, 4); add(1'b1, !v[i], 1'b0, 5);
    end
    add(1'b1, 1'b0, 1'b0, 5); add(1'b0, 1'b0, ack, 4); add(1'b1, 1'b0, 1'b0, 5);
    if (stop) add(1'b0, 1'b1, 1'b0, 4);
  endtask

  task automatic add_rbyte(input logic [7:0] v, input logic last, input logic stop);
    for (int i = 7; i >= 0; i--) begin
      add(1'b0, 1'b0, !v[i], 4); add(1'b1, 1'b0, 1'b0, 5);
    end
    add(1'b1, !last, 1'b0, 1); add(1'b0, !last, 1'b0, 4); add(1'b1, !last, 1'b0, 5);
    add(1'b1, 1'b0, 1'b0, 5);
    if (stop && last) add(1'b0, 1'b1, 1'b0, 4);
  endtask

  // Issue one command and follow the prepared segments cycle by cycle.
  task automatic run(input logic [1:0] op, input logic [7:0] d, input logic rnw,
                     input logic stop, input logic last, input logic hold,
                     input logic open_after, input string req);
    logic ok;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R10", "ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_rnw = rnw;
    cmd_stop = stop; cmd_last = last;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      cmd_op = 2'd1; cmd_data = ~d;
    end else begin
      cmd_valid = 1'b0;
    end
    for (int s = 0; s < nseg; s++) begin
      ok = 1'b1;
      if (hold && s == nseg - 1) cmd_valid = 1'b0;
      for (int c = 0; c < seg_t[s] * DIV; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (c == 0) begin
          slave_pull = seg_pull[s];
          check(cmd_ready == 1'b0, "R10", "ready while busy", cmd_ready, 0);
          if (s == 0)
            check(!ack_err && !addr_err, "R10", "flags cleared on accept",
                  {ack_err, addr_err}, 0);
        end
        if (scl_low !== seg_scl[s] || sda_low !== seg_sda[s]) ok = 1'b0;
      end
      if (!ok)
        $display("  segment %0d of %0d lines scl/sda=%0d/%0d", s, nseg, scl_low, sda_low);
      check(ok, req, "phase lines and length (R12)", s, s);
    end
    slave_pull = 1'b0;
    @(posedge clk);
    @(negedge clk);
    open_exp = open_after;
    check(cmd_ready == 1'b1, "R10", "ready after command", cmd_ready, 1);
    check(scl_low == !open_exp && sda_low == 1'b0, open_after ? "R7" : "R8",
          "idle lines", {scl_low, sda_low}, {!open_exp, 1'b0});
  endtask

  task automatic finish_all();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    finish_all();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1
    check(!scl_low && !sda_low, "R1", "lines after reset", {scl_low, sda_low}, 0);
    check(cmd_ready && !ack_err && !addr_err, "R1", "ready and flags after reset",
          {cmd_ready, ack_err, addr_err}, 4);

    // R2 R8 R9: every address
    for (int a = 0; a < 128; a++) begin
      logic [6:0] ad;
      logic       ack;
      ad  = 7'(a);
      ack = ad[0] ^ ad[3];
      if (ad[6:3] == 4'hF) begin
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = {1'b0, ad}; cmd_rnw = ad[1];
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(addr_err && cmd_ready, "R9", "reserved address refused",
              {addr_err, cmd_ready}, 3);
        for (int k = 0; k < 3; k++) begin
          check(scl_low == !open_exp && sda_low == 1'b0, "R9", "no bus activity",
                {scl_low, sda_low}, {!open_exp, 1'b0});
          @(negedge clk);
        end
        check(addr_err == 1'b1, "R10", "addr_err held", addr_err, 1);
      end else begin
        nseg = 0;
        add(1'b0, 1'b0, 1'b0, 5); add(1'b0, 1'b1, 1'b0, 4); add(1'b1, 1'b1, 1'b0, 5);
        add_wbyte({ad, ad[1]}, ack, 1'b0);
        run(2'd0, {1'b0, ad}, ad[1], ad[2], 1'b0, 1'b0, 1'b0, "R2");
        check(ack_err == !ack, "R4", "address acknowledge", ack_err, !ack);
        repeat (3) @(negedge clk);
        check(ack_err == !ack, "R10", "ack_err held while idle", ack_err, !ack);
      end
    end

    // R3 R4 R7: every write value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic       stp;
      b   = 8'(v);
      stp = b[0] ^ b[7];
      nseg = 0;
      add_wbyte(b, b[2], stp);
      run(2'd1, b, 1'b0, stp, 1'b0, 1'b0, stp, "R3");
      check(ack_err == !b[2], "R4", "write acknowledge", ack_err, !b[2]);
    end

    // R5 R6 R7: reads with all stop/last combinations
    for (int i = 0; i < 128; i++) begin
      logic [7:0] b;
      logic       lst, stp;
      b   = 8'((i * 73) & 255);
      lst = i[0];
      stp = i[1];
      nseg = 0;
      add_rbyte(b, lst, stp);
      run(2'd2, 8'h00, 1'b0, stp, lst, 1'b0, stp && lst, "R6");
      check(rd_data == b, "R5", "read byte", rd_data, b);
    end

    // R7: standalone stop
    nseg = 0;
    add(1'b0, 1'b1, 1'b0, 4);
    run(2'd3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");

    // R11: command held valid while busy
    nseg = 0;
    add(1'b0, 1'b0, 1'b0, 5); add(1'b0, 1'b1, 1'b0, 4); add(1'b1, 1'b1, 1'b0, 5);
    add_wbyte(8'hA0, 1'b1, 1'b0);
    run(2'd0, 8'h50, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
    check(ack_err == 1'b0, "R11", "busy command ignored, ack kept", ack_err, 0);

    finish_all();
  end
endmodule